// File: doc/BRIEF.md
# Receive Completion Ring Writer

This block records each finished packet reassembly as a four-word descriptor in a 256-slot ring that lives in host memory. When the reassembly engine raises its completion strobe, the block captures the status bits, the count of congestion-marked cells, the packet length in cells, the start address of the buffer and the 32-bit cell header. It then issues four single-word writes on a valid/ready write port and moves its slot index forward by one.

The ring slot for index `i` starts at `RING_BASE + i*16`. Word `w` of the descriptor goes to that slot start plus `w*4`, and the words are sent in the order 0, 1, 2, 3. The slot index is an 8-bit counter that wraps from 255 to 0, and it is always visible on an output so the host can find the next slot to be filled. A new completion is refused while a descriptor is still being written. The producer holds its request until the block accepts it.

Top module: `rx_cmpl_ring_writer`

## Requirements
- R1: After reset, `curIdx` is 0, `wrValid` is 0 and `cmplReady` is 1.
- R2: A completion is accepted at a clock edge where `cmplValid` and `cmplReady` are both 1. From the next cycle, `cmplReady` is 0 and `wrValid` is 1. `cmplReady` returns to 1 in the cycle after the fourth word write is accepted. `cmplReady` and `wrValid` are never 1 together.
- R3: The four words of a descriptor are sent in order 0 to 3, and word `w` of slot `i` is at address `RING_BASE + i*16 + w*4`. Address bits 3:2 carry the word number.
- R4: Word 0 holds the status in bits 31:29, zero in bits 28:22, the congestion-cell count in bits 21:11 and the packet length in bits 10:0.
- R5: Word 1 holds the 28-bit buffer pointer in bits 27:0 with bits 31:28 zero. Word 2 is the 32-bit header. Word 3 is all zero.
- R6: While `wrValid` is 1 and `wrReady` is 0, `wrValid`, `wrAddr` and `wrData` hold their values into the next cycle.
- R7: `curIdx` rises by one, wrapping from 255 to 0, in the cycle after the fourth word of a descriptor is accepted. It does not change at any other time.
- R8: Changes on the completion inputs after acceptance do not affect the descriptor being written.
- R9: A completion held on `cmplValid` while a descriptor is in progress is not lost and not duplicated. It is accepted once, at the first edge with `cmplReady` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmplValid | input | 1 | Packet reassembly finished, fields valid |
| cmplReady | output | 1 | Block can accept a completion |
| cmplStatus | input | 3 | Status bits for word 0 |
| cmplCongCnt | input | 11 | Congestion-marked cell count |
| cmplLen | input | 11 | Packet length in cells |
| cmplBufPtr | input | 28 | Start address of the receive buffer |
| cmplHeader | input | 32 | Cell header of the packet |
| wrValid | output | 1 | Write request valid |
| wrReady | input | 1 | Memory accepts the write |
| wrAddr | output | 32 | Byte address of the word |
| wrData | output | 32 | Word to write |
| curIdx | output | 8 | Ring slot that the next descriptor will fill |

## Verification
Two events can fall in the same cycle: the last word of one descriptor is accepted while the producer already holds the next completion. The bench creates this case by issuing completions back to back with no gap, under both steady and randomly stalling `wrReady`. A reference model running alongside the design expects `cmplReady` to stay low on that edge. It expects the waiting completion to be taken exactly one cycle later, as a separate descriptor in the next slot, with `curIdx` already advanced. Any lost, doubled or early descriptor shows up as an address, data or index mismatch.

// File: rtl/rxcr_pkg.sv
package rxcr_pkg;
  localparam int WORDS_PER_ENTRY = 4;
  localparam int WSEL_W = $clog2(WORDS_PER_ENTRY);

  // Strobes from control to datapath
  typedef struct packed {
    logic              load;     // capture completion fields
    logic              step;     // current word handed off
    logic              done;     // last word of the entry handed off
    logic [WSEL_W-1:0] wordSel;  // word being presented
  } ctlStrobe_t;
endpackage

// File: rtl/rxcr_ctrl.sv
module rxcr_ctrl
  import rxcr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmplValid,
  output logic       cmplReady,
  output logic       wrValid,
  input  logic       wrReady,
  output ctlStrobe_t strobe
);
  localparam logic [WSEL_W-1:0] LAST_WORD = WSEL_W'(WORDS_PER_ENTRY - 1);

  typedef enum logic {S_IDLE, S_WRITE} state_t;
  state_t            state;
  logic [WSEL_W-1:0] wordCnt;

  always_comb begin
    cmplReady      = (state == S_IDLE);
    wrValid        = (state == S_WRITE);
    strobe.load    = cmplReady && cmplValid;
    strobe.step    = wrValid && wrReady;
    strobe.done    = strobe.step && (wordCnt == LAST_WORD);
    strobe.wordSel = wordCnt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      wordCnt <= '0;
    end else if (strobe.load) begin
      state   <= S_WRITE;
      wordCnt <= '0;
    end else if (strobe.step) begin
      if (strobe.done) begin
        state   <= S_IDLE;
        wordCnt <= '0;
      end else begin
        wordCnt <= wordCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rxcr_datapath.sv
module rxcr_datapath
  import rxcr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 8,
  parameter int STAT_W = 3,
  parameter int CNT_W  = 11,
  parameter int LEN_W  = 11,
  parameter int PTR_W  = 28,
  parameter logic [ADDR_W-1:0] RING_BASE = 32'h0010_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [STAT_W-1:0] cmplStatus,
  input  logic [CNT_W-1:0]  cmplCongCnt,
  input  logic [LEN_W-1:0]  cmplLen,
  input  logic [PTR_W-1:0]  cmplBufPtr,
  input  logic [DATA_W-1:0] cmplHeader,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData,
  output logic [IDX_W-1:0]  curIdx
);
  localparam int BYTE_SHIFT = $clog2(DATA_W / 8);
  localparam int PAD0_W     = DATA_W - STAT_W - CNT_W - LEN_W;

  logic [DATA_W-1:0] newWord [WORDS_PER_ENTRY];
  logic [DATA_W-1:0] entryQ  [WORDS_PER_ENTRY];
  logic [IDX_W-1:0]  idxQ;

  // Descriptor layout, assembled from live inputs and captured on load
  always_comb begin
    newWord[0] = {cmplStatus, {PAD0_W{1'b0}}, cmplCongCnt, cmplLen};
    newWord[1] = DATA_W'(cmplBufPtr);
    newWord[2] = cmplHeader;
    newWord[3] = '0;
  end

  for (genvar w = 0; w < WORDS_PER_ENTRY; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rstN)            entryQ[w] <= '0;
      else if (strobe.load) entryQ[w] <= newWord[w];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)            idxQ <= '0;
    else if (strobe.done) idxQ <= idxQ + 1'b1;
  end

  assign wrData = entryQ[strobe.wordSel];
  assign wrAddr = RING_BASE + (ADDR_W'({idxQ, strobe.wordSel}) << BYTE_SHIFT);
  assign curIdx = idxQ;
endmodule

// File: rtl/rx_cmpl_ring_writer.sv
module rx_cmpl_ring_writer
  import rxcr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 8,
  parameter int STAT_W = 3,
  parameter int CNT_W  = 11,
  parameter int LEN_W  = 11,
  parameter int PTR_W  = 28,
  parameter logic [ADDR_W-1:0] RING_BASE = 32'h0010_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmplValid,
  output logic              cmplReady,
  input  logic [STAT_W-1:0] cmplStatus,
  input  logic [CNT_W-1:0]  cmplCongCnt,
  input  logic [LEN_W-1:0]  cmplLen,
  input  logic [PTR_W-1:0]  cmplBufPtr,
  input  logic [DATA_W-1:0] cmplHeader,
  output logic              wrValid,
  input  logic              wrReady,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData,
  output logic [IDX_W-1:0]  curIdx
);
  ctlStrobe_t strobe;

  rxcr_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .cmplValid (cmplValid),
    .cmplReady (cmplReady),
    .wrValid   (wrValid),
    .wrReady   (wrReady),
    .strobe    (strobe)
  );

  rxcr_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .STAT_W(STAT_W),
    .CNT_W(CNT_W), .LEN_W(LEN_W), .PTR_W(PTR_W), .RING_BASE(RING_BASE)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .cmplStatus  (cmplStatus),
    .cmplCongCnt (cmplCongCnt),
    .cmplLen     (cmplLen),
    .cmplBufPtr  (cmplBufPtr),
    .cmplHeader  (cmplHeader),
    .wrAddr      (wrAddr),
    .wrData      (wrData),
    .curIdx      (curIdx)
  );
endmodule

// File: rtl/rxcr_checker.sv
module rxcr_checker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmplValid,
  input logic              cmplReady,
  input logic              wrValid,
  input logic              wrReady,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [DATA_W-1:0] wrData,
  input logic [IDX_W-1:0]  curIdx
);
  localparam int BYTE_SHIFT = $clog2(DATA_W / 8);

  logic [1:0] hsCnt;
  logic       hs;
  logic       lastHs;
  assign hs     = wrValid && wrReady;
  assign lastHs = hs && (hsCnt == 2'd3);

  always_ff @(posedge clk) begin
    if (!rstN)   hsCnt <= '0;
    else if (hs) hsCnt <= hsCnt + 1'b1;
  end

  a_r2_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(cmplReady && wrValid));
  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rstN)
    cmplValid && cmplReady |=> !cmplReady && wrValid);
  a_r2_release: assert property (@(posedge clk) disable iff (!rstN)
    lastHs |=> cmplReady);
  a_r3_word_order: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |-> wrAddr[BYTE_SHIFT +: 2] == hsCnt);
  a_r5_word3_zero: assert property (@(posedge clk) disable iff (!rstN)
    wrValid && hsCnt == 2'd3 |-> wrData == '0);
  a_r6_hold: assert property (@(posedge clk) disable iff (!rstN)
    wrValid && !wrReady |=> wrValid && $stable(wrAddr) && $stable(wrData));
  a_r7_advance: assert property (@(posedge clk) disable iff (!rstN)
    lastHs |=> curIdx == IDX_W'($past(curIdx) + 1'b1));
  a_r7_steady: assert property (@(posedge clk) disable iff (!rstN)
    !lastHs |=> $stable(curIdx));
endmodule

bind rx_cmpl_ring_writer rxcr_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)
) chk_i (
  .clk(clk), .rstN(rstN), .cmplValid(cmplValid), .cmplReady(cmplReady),
  .wrValid(wrValid), .wrReady(wrReady), .wrAddr(wrAddr), .wrData(wrData),
  .curIdx(curIdx)
);

// File: tb/rx_cmpl_ring_writer_tb_top.sv
module rx_cmpl_ring_writer_tb_top;
  localparam logic [31:0] BASE = 32'h0010_0000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmplValid = 1'b0;
  logic        cmplReady;
  logic [2:0]  cmplStatus = '0;
  logic [10:0] cmplCongCnt = '0;
  logic [10:0] cmplLen = '0;
  logic [27:0] cmplBufPtr = '0;
  logic [31:0] cmplHeader = '0;
  logic        wrValid;
  logic        wrReady = 1'b1;
  logic [31:0] wrAddr;
  logic [31:0] wrData;
  logic [7:0]  curIdx;

  always #2 clk = ~clk;  // 250 MHz

  rx_cmpl_ring_writer dut_i (.*);

  typedef struct {
    logic [2:0]  st;
    logic [10:0] cc;
    logic [10:0] ln;
    logic [27:0] bp;
    logic [31:0] hd;
    logic [7:0]  ix;
  } entry_t;

  entry_t      expQ[$];
  int          nTests = 0;
  int          nFail = 0;
  int          readyPct = 100;
  int          nSubmitted = 0;
  bit          busyM = 0;
  int          wM = 0;
  logic [7:0]  idxM = '0;
  bit          prevStall = 0;
  logic [31:0] prevAddr, prevData;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] expWord(entry_t e, int w);
    case (w)
      0:       return {e.st, 7'b0, e.cc, e.ln};  // R4
      1:       return {4'b0, e.bp};              // R5
      2:       return e.hd;                      // R5
      default: return 32'h0;                     // R5
    endcase
  endfunction

  function automatic logic [31:0] expAddr(logic [7:0] ix, int w);
    return BASE + 32'(ix) * 32'd16 + 32'(w) * 32'd4;
  endfunction

  task automatic scramble();
    cmplStatus  = 3'($urandom);
    cmplCongCnt = 11'($urandom);
    cmplLen     = 11'($urandom);
    cmplBufPtr  = 28'($urandom);
    cmplHeader  = $urandom;
  endtask

  // Drive one completion, hold until taken (R9), then scramble inputs (R8)
  task automatic submit(input logic [2:0] st, input logic [10:0] cc, input logic [10:0] ln,
                        input logic [27:0] bp, input logic [31:0] hd, input int gap);
    cmplStatus = st; cmplCongCnt = cc; cmplLen = ln; cmplBufPtr = bp; cmplHeader = hd;
    cmplValid = 1'b1;
    forever begin
      @(negedge clk);
      if (cmplReady) break;
    end
    @(posedge clk); #1;
    cmplValid = 1'b0;
    nSubmitted++;
    scramble();
    repeat (gap) begin @(posedge clk); #1; scramble(); end
  endtask

  task automatic submitRandom(input int gap);
    submit(3'($urandom), 11'($urandom), 11'($urandom), 28'($urandom), $urandom, gap);
  endtask

  initial forever begin
    @(posedge clk); #1;
    wrReady = ($urandom_range(99) < readyPct);
  end

  // Reference model and output checks, sampled at the falling edge
  always @(negedge clk) begin
    if (rstN) begin
      chk(cmplReady == !busyM, "R2", 32'(cmplReady), 32'(!busyM));
      chk(wrValid == busyM, "R2", 32'(wrValid), 32'(busyM));
      chk(curIdx == idxM, "R7", 32'(curIdx), 32'(idxM));
      if (busyM && cmplValid)
        chk(!cmplReady, "R9", 32'(cmplReady), 32'd0);
      if (prevStall) begin
        chk(wrValid && wrAddr == prevAddr, "R6", wrAddr, prevAddr);
        chk(wrData == prevData, "R6", wrData, prevData);
      end
      if (wrValid && expQ.size() > 0) begin
        chk(wrAddr == expAddr(expQ[0].ix, wM), "R3", wrAddr, expAddr(expQ[0].ix, wM));
        // Inputs are scrambled after acceptance, so a match also covers R8
        chk(wrData == expWord(expQ[0], wM), (wM == 0) ? "R4" : "R5", wrData, expWord(expQ[0], wM));
      end
      if (wrValid && wrReady) begin
        wM++;
        if (wM == 4) begin
          wM = 0;
          void'(expQ.pop_front());
          idxM = idxM + 8'd1;
          busyM = 0;
        end
      end
      if (cmplValid && cmplReady) begin
        expQ.push_back('{cmplStatus, cmplCongCnt, cmplLen, cmplBufPtr, cmplHeader, idxM});
        busyM = 1;
      end
      prevStall = wrValid && !wrReady;
      prevAddr  = wrAddr;
      prevData  = wrData;
    end
  end

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    void'($urandom(32'h00C0FFEE));
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    chk(curIdx == 8'd0, "R1", 32'(curIdx), 32'd0);
    chk(!wrValid, "R1", 32'(wrValid), 32'd0);
    chk(cmplReady, "R1", 32'(cmplReady), 32'd1);
    @(posedge clk); #1;

    // Directed: all ones, all zeros
    submit(3'h7, 11'h7FF, 11'h7FF, 28'hFFF_FFFF, 32'hFFFF_FFFF, 6);
    submit(3'h0, 11'h0, 11'h0, 28'h0, 32'h0, 6);
    // Back to back: completion held while the last word goes out (R9)
    for (int i = 0; i < 3; i++) submitRandom(0);
    // Random stalls on the write port (R6)
    readyPct = 40;
    for (int i = 0; i < 100; i++) submitRandom($urandom_range(3));
    // Ring wrap past slot 255 (R7)
    readyPct = 100;
    for (int i = 0; i < 260; i++) submitRandom(($urandom_range(3) == 0) ? 1 : 0);

    repeat (40) @(posedge clk);
    @(negedge clk);
    chk(curIdx == 8'(nSubmitted), "R7", 32'(curIdx), 32'(8'(nSubmitted)));
    chk(expQ.size() == 0, "R9", 32'(expQ.size()), 32'd0);
    finishRun();
  end
endmodule